// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after a start pulse. It reads a small configuration image from a 3-wire serial EEPROM by driving chip select, clock and data-out pins directly. It reads every word of the array in address order. Each word is fetched in its own frame: a 9-bit read request goes out and 16 data bits come back. Every pin level is held for a fixed settling time, which a counter derives from the clock frequency.

While the words stream in, the block keeps a 16-bit running sum and captures the two words that hold the adapter settings. The words are laid out little-endian, so byte offset 2n is the low byte of word n. At the end of the image the sum is compared with a fixed signature. If the sum matches, the decoded outputs are loaded: host bus ID, tagged-queue depth and active-negation enable. If it does not match, the outputs keep their defaults. A one-cycle done pulse marks the end of the load. The valid flag then holds its value until the next accepted start.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: After reset, chip select and serial clock are low, done and valid are 0, the host ID is 7, the queue depth is 0 and active negation is 0.
- R2: Each frame shifts out 9 bits MSB first on the data-out pin: a 1, then the read command 0x80 plus the word index. The data-out pin is stable from at least one hold interval before each rising clock until that clock falls.
- R3: One load reads words 0 through 63 in increasing order, one frame per word, so the commands run from 0x80 to 0xBF.
- R4: After the command, 16 data bits are taken from the data-in pin MSB first, one per clock pulse. Each bit is sampled while the clock is high, at the end of that hold interval.
- R5: Chip select and the serial clock never change level less than HOLD cycles after their previous change, where HOLD = CLK_KHZ*HOLD_US/1000 (minimum 1).
- R6: Chip select falls between words and stays low for at least HOLD cycles. The serial clock is never high while chip select is low.
- R7: When the 16-bit wrap-around sum of all 64 words equals 0x1234, valid is 1 and the outputs are decoded. The host ID is byte 0x40 (low byte of word 32). Active negation is bit 3 of byte 0x41 (bit 11 of word 32). The queue depth is 2 shifted left by byte 0x43 (high byte of word 33), truncated to 16 bits, so exponents of 15 and above give 0.
- R8: When the sum differs from 0x1234, valid is 0 and the outputs show the defaults: host ID 7, depth 0, active negation 0.
- R9: Done is high for exactly one cycle per load, in the same cycle that valid and the decoded outputs take their final values. Valid and the outputs then stay unchanged until the next accepted start. An accepted start drives valid to 0 and the outputs to their defaults.
- R10: A start pulse during a load is ignored: the load still makes exactly 64 frames and one done pulse, and its result is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a load when idle |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM |
| done | output | 1 | One-cycle end-of-load pulse |
| valid | output | 1 | Image checksum matched |
| hostId | output | 8 | Decoded host bus ID |
| queueDepth | output | 16 | Decoded tagged-queue depth |
| activeNeg | output | 1 | Decoded active-negation enable |

## Verification
A wrong sequencer state shows up on the pins within one hold interval. It appears as a short pin level, a clock pulse outside chip select, a start bit missing from a frame, or an address out of sequence. The bench's serial memory model flags each of these at the pulse where it happens. A wrong bit count, sum or capture stays hidden until the end of the load. It then appears as a wrong valid flag or wrong decoded fields in the cycle done pulses. The checksum images are therefore built so that both the wrap-around and a single-bit error change that final result.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clearAll;   // new load accepted
    logic loadTx;     // load request frame
    logic shiftTx;    // advance to next request bit
    logic clearBits;  // request sent, start data phase
    logic sampleRx;   // capture one data bit
    logic storeWord;  // word complete: sum and capture
    logic nextWord;   // advance word index
    logic finish;     // evaluate checksum, publish
  } strobe_t;

  localparam int          CFG_WORD_A = 32;       // bytes 0x40 (id) and 0x41 (flags)
  localparam int          CFG_WORD_B = 33;       // byte 0x43 (queue exponent)
  localparam int          NEG_BIT    = 11;       // bit 3 of the high byte
  localparam logic [15:0] IMAGE_SUM  = 16'h1234;
  localparam logic [7:0]  DEFAULT_ID = 8'd7;
  localparam logic [1:0]  READ_OP    = 2'b10;

endpackage

// File: rtl/eecfg_ctrl.sv
module eecfg_ctrl
  import eecfg_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    txLast,
  input  logic    rxLast,
  input  logic    lastWord,
  output strobe_t str,
  output logic    pinCs,
  output logic    pinSk
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CSON, S_TXSET, S_TXHI, S_TXLO, S_RXHI, S_RXLO, S_GAP, S_CHECK
  } state_t;

  state_t st, stNext;
  logic [HOLD_W-1:0] holdCnt;
  logic holdDone;

  assign holdDone = (holdCnt == '0);

  always_comb begin
    stNext = st;
    str    = '0;
    unique case (st)
      S_IDLE: if (start) begin
        str.clearAll = 1'b1;
        stNext       = S_CSON;
      end
      S_CSON: if (holdDone) begin
        str.loadTx = 1'b1;
        stNext     = S_TXSET;
      end
      S_TXSET: if (holdDone) stNext = S_TXHI;
      S_TXHI:  if (holdDone) stNext = S_TXLO;
      S_TXLO: if (holdDone) begin
        if (txLast) begin
          str.clearBits = 1'b1;
          stNext        = S_RXHI;
        end else begin
          str.shiftTx = 1'b1;
          stNext      = S_TXSET;
        end
      end
      S_RXHI: if (holdDone) begin
        str.sampleRx = 1'b1;
        stNext       = S_RXLO;
      end
      S_RXLO: if (holdDone) begin
        if (rxLast) begin
          str.storeWord = 1'b1;
          stNext        = S_GAP;
        end else begin
          stNext = S_RXHI;
        end
      end
      S_GAP: if (holdDone) begin
        if (lastWord) begin
          stNext = S_CHECK;
        end else begin
          str.nextWord = 1'b1;
          stNext       = S_CSON;
        end
      end
      S_CHECK: begin
        str.finish = 1'b1;
        stNext     = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      holdCnt <= '0;
      pinCs   <= 1'b0;
      pinSk   <= 1'b0;
    end else begin
      st <= stNext;
      if (stNext != st)
        holdCnt <= HOLD_W'(HOLD_CYC - 1);
      else if (!holdDone)
        holdCnt <= holdCnt - 1'b1;
      pinCs <= (stNext == S_CSON) || (stNext == S_TXSET) || (stNext == S_TXHI) ||
               (stNext == S_TXLO) || (stNext == S_RXHI)  || (stNext == S_RXLO);
      pinSk <= (stNext == S_TXHI) || (stNext == S_RXHI);
    end
  end

endmodule

// File: rtl/eecfg_dp.sv
module eecfg_dp
  import eecfg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int QD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           str,
  input  logic              din,
  output logic              txLast,
  output logic              rxLast,
  output logic              lastWord,
  output logic              dout,
  output logic              done,
  output logic              valid,
  output logic [7:0]        hostId,
  output logic [QD_W-1:0]   queueDepth,
  output logic              activeNeg
);

  localparam int FRAME_W = ADDR_W + 3;
  localparam int CNT_MAX = (DATA_W > FRAME_W) ? DATA_W : FRAME_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int WORDS   = 1 << ADDR_W;

  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;
  logic [DATA_W-1:0]  sum;
  logic [CNT_W-1:0]   bitCnt;
  logic [ADDR_W-1:0]  wordIdx;
  logic [7:0]         idByte;
  logic [7:0]         expByte;
  logic               negFlag;
  logic               imageOk;

  assign dout     = txShift[FRAME_W-1];
  assign txLast   = (bitCnt == CNT_W'(FRAME_W - 1));
  assign rxLast   = (bitCnt == CNT_W'(DATA_W));
  assign lastWord = (wordIdx == ADDR_W'(WORDS - 1));
  assign imageOk  = (sum == DATA_W'(IMAGE_SUM));

  // Serial shift and counters
  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      rxShift <= '0;
      bitCnt  <= '0;
      wordIdx <= '0;
    end else begin
      if (str.clearAll) wordIdx <= '0;
      else if (str.nextWord) wordIdx <= wordIdx + 1'b1;

      if (str.loadTx) begin
        txShift <= {1'b1, READ_OP, wordIdx};
        bitCnt  <= '0;
      end else if (str.shiftTx) begin
        txShift <= txShift << 1;
        bitCnt  <= bitCnt + 1'b1;
      end else if (str.clearBits) begin
        bitCnt <= '0;
      end else if (str.sampleRx) begin
        rxShift <= {rxShift[DATA_W-2:0], din};
        bitCnt  <= bitCnt + 1'b1;
      end
    end
  end

  // Checksum and capture of the adapter words
  always_ff @(posedge clk) begin
    if (rst) begin
      sum     <= '0;
      idByte  <= '0;
      expByte <= '0;
      negFlag <= 1'b0;
    end else if (str.clearAll) begin
      sum <= '0;
    end else if (str.storeWord) begin
      sum <= sum + rxShift;
      if (wordIdx == ADDR_W'(CFG_WORD_A)) begin
        idByte  <= rxShift[7:0];
        negFlag <= rxShift[NEG_BIT];
      end
      if (wordIdx == ADDR_W'(CFG_WORD_B))
        expByte <= rxShift[15:8];
    end
  end

  // Published results
  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      valid      <= 1'b0;
      hostId     <= DEFAULT_ID;
      queueDepth <= '0;
      activeNeg  <= 1'b0;
    end else begin
      done <= str.finish;
      if (str.clearAll) begin
        valid      <= 1'b0;
        hostId     <= DEFAULT_ID;
        queueDepth <= '0;
        activeNeg  <= 1'b0;
      end else if (str.finish) begin
        valid <= imageOk;
        if (imageOk) begin
          hostId     <= idByte;
          queueDepth <= QD_W'(2) << expByte;
          activeNeg  <= negFlag;
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int CLK_KHZ = 40000,
  parameter int HOLD_US = 160,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int QD_W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            eeCs,
  output logic            eeSk,
  output logic            eeDi,
  input  logic            eeDo,
  output logic            done,
  output logic            valid,
  output logic [7:0]      hostId,
  output logic [QD_W-1:0] queueDepth,
  output logic            activeNeg
);

  localparam int HOLD_RAW = (CLK_KHZ * HOLD_US) / 1000;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

  strobe_t str;
  logic txLast, rxLast, lastWord;

  eecfg_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .txLast(txLast), .rxLast(rxLast), .lastWord(lastWord),
    .str(str), .pinCs(eeCs), .pinSk(eeSk)
  );

  eecfg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QD_W(QD_W)) u_dp (
    .clk(clk), .rst(rst), .str(str), .din(eeDo),
    .txLast(txLast), .rxLast(rxLast), .lastWord(lastWord),
    .dout(eeDi), .done(done), .valid(valid), .hostId(hostId),
    .queueDepth(queueDepth), .activeNeg(activeNeg)
  );

endmodule

// File: rtl/eecfg_loader_chk.sv
module eecfg_loader_chk #(
  parameter int HOLD_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic eeCs,
  input logic eeSk,
  input logic eeDi,
  input logic done,
  input logic valid
);

  localparam int AGE_W = $clog2(HOLD_CYC + 1);

  logic [1:0]       pinsPrev;
  logic [AGE_W-1:0] sinceEdge;
  logic             pinsChanged;

  assign pinsChanged = ({eeCs, eeSk} != pinsPrev);

  always_ff @(posedge clk) begin
    if (rst) begin
      pinsPrev  <= 2'b00;
      sinceEdge <= AGE_W'(HOLD_CYC);
    end else begin
      pinsPrev <= {eeCs, eeSk};
      if (pinsChanged) sinceEdge <= AGE_W'(1);
      else if (sinceEdge != AGE_W'(HOLD_CYC)) sinceEdge <= sinceEdge + 1'b1;
    end
  end

  p_pin_hold_r5: assert property (@(posedge clk) disable iff (rst)
    pinsChanged |-> (sinceEdge >= AGE_W'(HOLD_CYC)));

  p_data_setup_r2: assert property (@(posedge clk) disable iff (rst)
    eeSk |-> $stable(eeDi));

  p_clock_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    !eeCs |-> !eeSk);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> done);

  p_valid_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(valid) |-> eeCs);

endmodule

bind eeprom_cfg_loader eecfg_loader_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst(rst), .eeCs(eeCs), .eeSk(eeSk),
  .eeDi(eeDi), .done(done), .valid(valid)
);

// File: tb/tb_eeprom_cfg_loader.sv
module tb_eeprom_cfg_loader;

  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic eeDo = 1'b0;
  logic eeCs, eeSk, eeDi, done, valid, activeNeg;
  logic [7:0]  hostId;
  logic [15:0] queueDepth;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  eeprom_cfg_loader #(.CLK_KHZ(1000), .HOLD_US(HOLD)) dut (
    .clk(clk), .rst(rst), .start(start), .eeCs(eeCs), .eeSk(eeSk),
    .eeDi(eeDi), .eeDo(eeDo), .done(done), .valid(valid), .hostId(hostId),
    .queueDepth(queueDepth), .activeNeg(activeNeg)
  );

  // Serial memory model with protocol monitor
  logic [15:0] mem [64];
  int   frames, protoErr, doneCount, bitIdx, expAddr, age, diAge;
  logic [8:0] cmdSr;
  logic [5:0] curAddr;
  logic prevCs = 1'b0, prevSk = 1'b0, prevDi = 1'b0;

  initial begin
    frames = 0; protoErr = 0; doneCount = 0; bitIdx = 0; expAddr = 0;
    age = 1000; diAge = 1000; cmdSr = '0; curAddr = '0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (eeCs !== prevCs || eeSk !== prevSk) begin
        if (age < HOLD) protoErr++;
        age = 1;
      end else age++;
      if (eeDi !== prevDi) diAge = 1; else diAge++;
      if (eeSk && !eeCs) protoErr++;
      if (done) doneCount++;
      if (!prevCs && eeCs) bitIdx = 0;
      if (prevCs && !eeCs) begin
        frames++;
        if (bitIdx != 25) protoErr++;
      end
      if (eeSk && !prevSk && eeCs) begin
        if (bitIdx < 9) begin
          if (diAge < HOLD) protoErr++;
          cmdSr = {cmdSr[7:0], eeDi};
          if (bitIdx == 8) begin
            if (cmdSr !== {1'b1, 2'b10, 6'(expAddr)}) protoErr++;
            curAddr = cmdSr[5:0];
            expAddr++;
          end
        end else if (bitIdx < 25) begin
          eeDo = mem[curAddr][24 - bitIdx];
        end else protoErr++;
        bitIdx++;
      end
    end
    prevCs = eeCs; prevSk = eeSk; prevDi = eeDi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Image: fill pattern, adapter words, then fix last word for the sum
  task automatic build_image(input logic [15:0] seed, input logic [7:0] id,
                             input logic [7:0] flags, input logic [7:0] expo,
                             input bit good);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 64; i++) mem[i] = seed ^ 16'(i * 16'h0913);
    mem[32] = {flags, id};
    mem[33] = {expo, mem[33][7:0]};
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = 16'h1234 - s;
    if (!good) mem[10] = mem[10] ^ 16'h0001;
  endtask

  task automatic run_load(input int midStartAt);
    frames = 0; protoErr = 0; doneCount = 0; expAddr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (midStartAt > 0) begin
      repeat (midStartAt) @(negedge clk);
      check(valid == 1'b0 && hostId == 8'd7, "R9", "mid-load defaults",
            {valid, hostId}, {1'b0, 8'd7});
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic check_protocol(input string tag);
    check(protoErr == 0, "R2", {tag, " framing/hold errors (R3 R4 R5 R6)"}, protoErr, 0);
    check(frames == 64, "R3", {tag, " frame count"}, frames, 64);
    check(doneCount == 1, "R9", {tag, " done pulses"}, doneCount, 1);
  endtask

  task automatic test_reset();
    check(!eeCs && !eeSk && !done && !valid, "R1", "pins/flags after reset",
          {eeCs, eeSk, done, valid}, 0);
    check(hostId == 8'd7 && queueDepth == 16'd0 && !activeNeg, "R1",
          "decoded defaults", {hostId, queueDepth, activeNeg}, {8'd7, 16'd0, 1'b0});
  endtask

  task automatic test_valid_image();
    build_image(16'h5A3C, 8'h05, 8'h08, 8'd4, 1'b1);
    run_load(0);
    check_protocol("valid");
    check(valid == 1'b1, "R7", "valid flag", valid, 1);
    check(hostId == 8'h05, "R7", "host id from byte 0x40 (R4 order)", hostId, 8'h05);
    check(activeNeg == 1'b1, "R7", "active negation", activeNeg, 1);
    check(queueDepth == 16'd32, "R7", "queue depth", queueDepth, 32);
    repeat (100) @(negedge clk);
    check(valid == 1'b1 && hostId == 8'h05 && queueDepth == 16'd32, "R9",
          "results held after done", {valid, hostId, queueDepth}, {1'b1, 8'h05, 16'd32});
  endtask

  task automatic test_bad_checksum();
    build_image(16'h5A3C, 8'h05, 8'h08, 8'd4, 1'b0);
    run_load(0);
    check_protocol("bad");
    check(valid == 1'b0, "R8", "valid flag on bad sum", valid, 0);
    check(hostId == 8'd7 && queueDepth == 16'd0 && !activeNeg, "R8",
          "defaults on bad sum", {hostId, queueDepth, activeNeg}, {8'd7, 16'd0, 1'b0});
  endtask

  task automatic test_wrap_and_big_exp();
    build_image(16'hF0E1, 8'h03, 8'hF7, 8'd15, 1'b1);
    run_load(0);
    check_protocol("wrap");
    check(valid == 1'b1, "R7", "wrap-around sum accepted", valid, 1);
    check(hostId == 8'h03, "R7", "host id", hostId, 8'h03);
    check(activeNeg == 1'b0, "R7", "negation bit 3 clear with others set", activeNeg, 0);
    check(queueDepth == 16'd0, "R7", "exponent 15 truncates to 0", queueDepth, 0);
  endtask

  task automatic test_start_ignored();
    build_image(16'h1111, 8'h0E, 8'h08, 8'd14, 1'b1);
    run_load(3000);
    check_protocol("restart");
    check(valid == 1'b1 && hostId == 8'h0E, "R10", "result with start mid-load",
          {valid, hostId}, {1'b1, 8'h0E});
    check(queueDepth == 16'h8000, "R10", "depth exponent 14", queueDepth, 16'h8000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_valid_image();
    test_bad_checksum();
    test_wrap_and_big_exp();
    test_start_ignored();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule